// File: doc/BRIEF.md
# Serial PHY Management Controller

This block lets a host reach the registers of an external Ethernet PHY over the two-wire management bus, which has a clock line and a bidirectional data line. The host writes a mode word, a PHY/register address and, for a write, a 16-bit data word into a small register file. It then writes a command word. The controller derives the management clock from the system clock through an even divider and shifts out a clause-22 frame. The frame holds an optional 32-bit preamble of ones, a start code, an opcode, two 5-bit addresses, a turnaround and 16 data bits sent MSB first. For a read, the controller releases the data line at the turnaround and shifts in the 16 data bits the PHY returns.

The host polls a status word for the busy flag and then reads the captured data. It writes zero to the command register after each operation. A scan command makes the controller read the addressed register again and again. While scanning, a link-fail flag follows bit 2 of the latest result, and an invalid flag stays set until the first scan result has arrived. The data line is split into an output, an output enable and an input, so that the pad sits outside the block.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the status word reads 0, the receive-data register reads 0, and the clock line, data output and output enable are all low.
- R2: The clock line runs only while a frame is in progress. Its period is 2*max(D,1) system clocks, where D is mode bits 7:1. Mode bit 0 is ignored and reads back as 0.
- R3: When mode bit 8 is 0 a frame starts with 32 ones of preamble. When it is 1, the frame starts directly with the start code 01.
- R4: Command bit 2 starts a write frame: 01, opcode 01, PHY address (address-register bits 4:0), register address (bits 12:8), turnaround 10, then transmit-data bits 15:0. All fields are sent MSB first, and the output enable is high for every bit.
- R5: Command bit 1 starts a read frame: 01, opcode 10, then the PHY and register addresses. The output enable drops for the 2 turnaround bits and the 16 data bits. The input is sampled on each rising clock edge, and the 16 bits are stored MSB first in receive-data bits 15:0. A write leaves receive-data unchanged.
- R6: The data output changes only in the system cycle in which the management clock falls.
- R7: The busy flag (status bit 1) is high from the clock edge that takes a command until the frame's last falling clock edge. The output enable is low whenever busy is low.
- R8: Read or write command bits written while busy is high start no frame. Neither receive-data nor the bus is affected afterwards.
- R9: Command bit 0 starts back-to-back read frames of the addressed register. It sets invalid (status bit 2) until the first scan frame completes. Each completed scan frame sets link fail (status bit 0) to the inverse of received bit 2. Writing bit 0 as 0 stops the scan after the current frame.
- R10: Host registers by word index: 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data (read-only), 5 status (read-only). The address register reads back only bits 12:8 and 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register word index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational from reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
A command takes effect at the clock edge that samples the write, so busy and the first frame bit are visible one half-cycle later. The bench reads status on the falling system-clock edge right after its write. The first rising management-clock edge comes max(D,1) system cycles after that. The bench samples every line on falling system-clock edges and captures a bit on each observed rise. It drives the PHY answer only after an observed fall, so each bit is stable for at least one system cycle before the controller samples it. Receive-data and the status flags are updated at the same edge that ends the frame. They are checked only after busy has been polled low, and the scan flags are checked after a counted number of completed frames.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 4 + 2 * ADDR_W;
    localparam int SHORT_LEN = HDR_LEN + 2 + DATA_W;
    localparam int FRAME_LEN = PRE_LEN + SHORT_LEN;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int HALF_W    = 7;

    localparam logic [2:0] RIDX_MODE = 3'd0;
    localparam logic [2:0] RIDX_CMD  = 3'd1;
    localparam logic [2:0] RIDX_ADDR = 3'd2;
    localparam logic [2:0] RIDX_TXD  = 3'd3;
    localparam logic [2:0] RIDX_RXD  = 3'd4;
    localparam logic [2:0] RIDX_STAT = 3'd5;

    typedef enum logic {
        MOP_READ  = 1'b0,
        MOP_WRITE = 1'b1
    } mop_e;

    typedef struct packed {
        mop_e              op;
        logic              skip_pre;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mreq_t;

    // Build the whole frame left-aligned so the first bit to send is the MSB.
    function automatic logic [FRAME_LEN-1:0] pack_frame(input mreq_t r);
        logic [SHORT_LEN-1:0] body;
        logic [1:0]           opc;
        logic [1:0]           ta;
        logic [DATA_W-1:0]    dat;
        opc  = (r.op == MOP_WRITE) ? 2'b01 : 2'b10;
        ta   = (r.op == MOP_WRITE) ? 2'b10 : 2'b00;
        dat  = (r.op == MOP_WRITE) ? r.wdata : '0;
        body = {2'b01, opc, r.phy, r.regad, ta, dat};
        if (r.skip_pre)
            return {body, {PRE_LEN{1'b1}}};
        return {{PRE_LEN{1'b1}}, body};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise_stb,
    output logic              fall_stb
);

    logic [HALF_W-1:0] cnt_q;
    logic              mdc_q;
    logic              tick;

    // half is already clamped to at least 1 by the caller
    assign tick     = run && (cnt_q >= half - 1'b1);
    assign rise_stb = tick && !mdc_q;
    assign fall_stb = tick && mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc_q);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mreq_t             req,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] DRIVE_MIN  = CNT_W'(DATA_W + 2);
    localparam logic [CNT_W-1:0] DATA_SPAN  = CNT_W'(DATA_W);

    logic [FRAME_LEN-1:0] sh_q;
    logic [CNT_W-1:0]     left_q;
    logic [CNT_W-1:0]     left_nx;
    logic                 busy_q;
    logic                 wr_q;
    logic                 oe_q;
    logic [DATA_W-1:0]    rd_q;

    assign left_nx = left_q - 1'b1;
    assign done    = busy_q && fall_stb && (left_q == '0);
    assign busy    = busy_q;
    assign mdio_o  = busy_q && sh_q[FRAME_LEN-1];
    assign mdio_oe = oe_q;
    assign rdata   = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            oe_q   <= 1'b0;
            rd_q   <= '0;
        end else if (start && !busy_q) begin
            sh_q   <= pack_frame(req);
            left_q <= req.skip_pre ? LAST_SHORT : LAST_FULL;
            busy_q <= 1'b1;
            wr_q   <= (req.op == MOP_WRITE);
            oe_q   <= 1'b1;
        end else if (busy_q) begin
            if (rise_stb && !wr_q && (left_q < DATA_SPAN))
                rd_q <= {rd_q[DATA_W-2:0], mdio_i};
            if (fall_stb) begin
                if (left_q == '0) begin
                    busy_q <= 1'b0;
                    oe_q   <= 1'b0;
                end else begin
                    sh_q   <= sh_q << 1;
                    left_q <= left_nx;
                    oe_q   <= wr_q || (left_nx >= DRIVE_MIN);
                end
            end
        end
    end

    // R6
    mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && !fall_stb |=> $stable(mdio_o));

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && !wr_q && (left_q < DATA_SPAN) |-> !oe_q);

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic [HALF_W-1:0] div_q;
    logic              nopre_q;
    logic              scan_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] regad_q;
    logic [DATA_W-1:0] txd_q;
    logic [DATA_W-1:0] rxd_q;
    logic              invalid_q;
    logic              linkf_q;
    logic              scan_frame_q;
    logic              rd_frame_q;

    logic              wr_cmd;
    logic              one_shot;
    logic              launch;
    logic              launch_scan;
    logic [HALF_W-1:0] half;
    mreq_t             req;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              rise_stb;
    logic              fall_stb;
    logic [15:0]       unused_wdata;

    assign unused_wdata = reg_wdata[31:16];

    assign wr_cmd      = reg_wr && (reg_addr == RIDX_CMD);
    assign one_shot    = wr_cmd && (reg_wdata[1] || reg_wdata[2]);
    assign launch_scan = wr_cmd ? reg_wdata[0] && !one_shot : scan_q;
    assign launch      = !eng_busy && (one_shot || launch_scan);
    assign half        = (div_q == '0) ? HALF_W'(1) : div_q;

    always_comb begin
        req.op       = (wr_cmd && reg_wdata[2]) ? MOP_WRITE : MOP_READ;
        req.skip_pre = nopre_q;
        req.phy      = phy_q;
        req.regad    = regad_q;
        req.wdata    = txd_q;
    end

    mdio_clkdiv u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (eng_busy),
        .half     (half),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (launch),
        .req      (req),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .done     (eng_done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rdata    (eng_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q        <= '0;
            nopre_q      <= 1'b0;
            scan_q       <= 1'b0;
            phy_q        <= '0;
            regad_q      <= '0;
            txd_q        <= '0;
            rxd_q        <= '0;
            invalid_q    <= 1'b0;
            linkf_q      <= 1'b0;
            scan_frame_q <= 1'b0;
            rd_frame_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    RIDX_MODE: begin
                        div_q   <= reg_wdata[HALF_W:1];
                        nopre_q <= reg_wdata[8];
                    end
                    RIDX_CMD:  scan_q <= reg_wdata[0];
                    RIDX_ADDR: begin
                        phy_q   <= reg_wdata[4:0];
                        regad_q <= reg_wdata[12:8];
                    end
                    RIDX_TXD:  txd_q <= reg_wdata[DATA_W-1:0];
                    default:   ;
                endcase
            end
            if (launch) begin
                scan_frame_q <= launch_scan;
                rd_frame_q   <= (req.op == MOP_READ);
            end
            if (eng_done && rd_frame_q)
                rxd_q <= eng_rdata;
            if (eng_done && scan_frame_q)
                linkf_q <= ~eng_rdata[2];
            if (wr_cmd && reg_wdata[0] && !scan_q)
                invalid_q <= 1'b1;
            else if ((eng_done && scan_frame_q) || (wr_cmd && !reg_wdata[0]))
                invalid_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            RIDX_MODE: reg_rdata = {23'd0, nopre_q, div_q, 1'b0};
            RIDX_CMD:  reg_rdata = {31'd0, scan_q};
            RIDX_ADDR: reg_rdata = {19'd0, regad_q, 3'd0, phy_q};
            RIDX_TXD:  reg_rdata = {16'd0, txd_q};
            RIDX_RXD:  reg_rdata = {16'd0, rxd_q};
            RIDX_STAT: reg_rdata = {29'd0, invalid_q, eng_busy, linkf_q};
            default:   reg_rdata = '0;
        endcase
    end

    // R7
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> !mdio_oe);

    // R5
    rxd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !eng_done |=> $stable(rxd_q));

    // R9
    invalid_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(invalid_q) |-> $past(eng_done || wr_cmd));

endmodule

// File: tb/tb_mdio_mgmt.sv
module tb_mdio_mgmt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b0;

    always #5 clk = ~clk;

    mdio_mgmt dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int tests = 0;
    int fails = 0;
    bit ended = 0;

    // vector: [35] write, [34] no preamble, [33:26] mode byte, [25:21] phy, [20:16] reg, [15:0] data
    localparam int NV = 5;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h04, 5'h01, 5'h00, 16'hA55A},
        {1'b0, 1'b0, 8'h05, 5'h1F, 5'h01, 16'h796D},
        {1'b1, 1'b1, 8'h00, 5'h10, 5'h1F, 16'h8001},
        {1'b0, 1'b1, 8'h01, 5'h05, 5'h0A, 16'h1234},
        {1'b0, 1'b0, 8'h0E, 5'h0C, 5'h13, 16'hFFFF}
    };

    // bus monitor and PHY model, all on falling system-clock edges
    int          cyc = 0;
    logic        mdc_q = 1'b0, oe_q = 1'b0, o_q = 1'b0;
    logic [63:0] cap = '0;
    int          drv = 0, rc = 0, ntot = 64, r1 = -1, r2 = -1;
    int          frames = 0, viol = 0;
    logic [15:0] phy_val = '0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mdio_oe && !oe_q) begin
            rc = 0; cap = '0; drv = 0; r1 = -1; r2 = -1;
            frames = frames + 1;
        end
        if (oe_q && mdio_oe && (mdio_o != o_q) && !(!mdc && mdc_q))
            viol = viol + 1;
        if (mdc && !mdc_q) begin
            if (mdio_oe) begin
                cap = {cap[62:0], mdio_o};
                drv = drv + 1;
            end
            if (r1 < 0) r1 = cyc;
            else if (r2 < 0) r2 = cyc;
            rc = rc + 1;
        end
        if (!mdc && mdc_q) begin
            if (rc >= ntot - 16 && rc < ntot)
                mdio_i <= phy_val[ntot - 1 - rc];
        end
        mdc_q <= mdc; oe_q <= mdio_oe; o_q <= mdio_o;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            rd(3'd5, s);
            if (!s[1]) break;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !ended) begin
            ended = 1;
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        logic [15:0] last_rx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd5, s); chk("R1 status", s, 0);
        rd(3'd4, s); chk("R1 rxdata", s, 0);
        chk("R1 pins", {mdc, mdio_o, mdio_oe}, 0);

        // R10 register readback masking
        wr(3'd0, 32'h0000_01FF); rd(3'd0, s); chk("R10 R2 mode bit0 forced 0", s, 32'h1FE);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, s); chk("R10 address mask", s, 32'h1F1F);

        last_rx = '0;
        for (int v = 0; v < NV; v++) begin
            logic        w, np;
            logic [7:0]  mb;
            logic [4:0]  ph, rg;
            logic [15:0] dt;
            logic [13:0] hdr;
            logic [63:0] exp_bits;
            int          exp_cnt, per, dv;
            {w, np, mb, ph, rg, dt} = VEC[v];
            hdr = {2'b01, (w ? 2'b01 : 2'b10), ph, rg};
            if (w) begin
                exp_bits = np ? {32'd0, hdr, 2'b10, dt} : {32'hFFFF_FFFF, hdr, 2'b10, dt};
                exp_cnt  = np ? 32 : 64;
            end else begin
                exp_bits = np ? {50'd0, hdr} : {18'd0, 32'hFFFF_FFFF, hdr};
                exp_cnt  = np ? 14 : 46;
            end
            dv  = mb[7:1];
            per = 2 * ((dv == 0) ? 1 : dv);
            ntot = np ? 32 : 64;
            phy_val = w ? 16'h0 : dt;
            wr(3'd0, {23'd0, np, mb});
            wr(3'd2, {19'd0, rg, 3'd0, ph});
            wr(3'd3, {16'd0, (w ? dt : 16'hDEAD)});
            wr(3'd1, w ? 32'h4 : 32'h2);
            rd(3'd5, s); chk("R7 busy after command", s[1], 1);
            wait_idle();
            chk("R4 R5 R3 driven bit count", drv, exp_cnt);
            chk("R4 R5 R3 driven bits", cap, exp_bits);
            chk("R2 mdc period", r2 - r1, per);
            chk("R7 oe low when idle", mdio_oe, 0);
            if (!w) last_rx = dt;
            rd(3'd4, s); chk("R5 rxdata", s, {16'd0, last_rx});
            wr(3'd1, 32'h0);
        end
        chk("R6 output changes only at mdc fall", viol, 0);

        // R8 command while busy is ignored
        begin
            int f0;
            ntot = 32; phy_val = 16'h0F0F;
            wr(3'd0, 32'h100);
            wr(3'd3, 32'h0000_3C3C);
            wr(3'd1, 32'h4);
            wr(3'd1, 32'h2);
            f0 = frames;
            wait_idle();
            repeat (200) @(negedge clk);
            chk("R8 no extra frame", frames, f0);
            rd(3'd4, s); chk("R8 rxdata untouched", s, {16'd0, last_rx});
        end

        // R9 scan mode
        begin
            int f0;
            ntot = 32; phy_val = 16'h7809;
            wr(3'd2, {19'd0, 5'h01, 3'd0, 5'h03});
            wr(3'd1, 32'h1);
            rd(3'd5, s); chk("R9 invalid and busy at scan start", s, 32'h6);
            for (int i = 0; i < 2000; i++) begin
                @(negedge clk); rd(3'd5, s);
                if (!s[2]) break;
            end
            rd(3'd5, s); chk("R9 link fail set", {s[2], s[0]}, 2'b01);
            rd(3'd4, s); chk("R9 scan rxdata", s, 32'h7809);
            phy_val = 16'h782D;
            f0 = frames;
            for (int i = 0; i < 2000; i++) begin
                @(negedge clk);
                if (frames >= f0 + 3) break;
            end
            rd(3'd5, s); chk("R9 link fail cleared", s[0], 0);
            rd(3'd4, s); chk("R9 scan rxdata update", s, 32'h782D);
            wr(3'd1, 32'h0);
            wait_idle();
            f0 = frames;
            repeat (100) @(negedge clk);
            chk("R9 scan stops", frames, f0);
            rd(3'd5, s); chk("R9 status after stop", s, 0);
        end

        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule